// File: doc/BRIEF.md
# Opcode-Driven Sensor Configuration Register Port

This block is the serial host port of a discrete-input sensing front end. A host drives a four-wire serial bus in SPI Mode 0. The block lets the host program a small set of configuration registers and read back the state of 32 sensed input lines. Every instruction starts with an 8-bit opcode. Opcode bit 7 chooses the direction. The opcode alone sets how many data bytes follow.

Configuration lives in the following registers:

- a general control byte;
- a 4-bit bank-type field, one bit per group of 8 sense lines;
- two 16-bit threshold words, one for ground/open sensing and one for supply/open sensing;
- a test byte.

All registers drive parallel outputs toward the analog side. The sense lines can be read one group of 8 at a time, or all 32 together. For the 32-bit read, one snapshot is captured when the opcode completes.

The block runs on a system clock that oversamples the serial clock, chip select and serial input through a synchronizer. Serial output is a data bit plus a separate enable for the pad. An active-low master reset clears all state.

Top module: `sense_spi_regif`

## Requirements
- R1: SI is sampled on rising SCK edges and SO changes only on falling SCK edges, both MSB first; SO holds its value through the high half of SCK.
- R2: The first 8 rising SCK edges after chip select falls form the opcode; bit 7 = 1 makes the instruction a read, which never alters a register.
- R3: Single-byte writes load on the 8th rising edge of the data byte: 0x02 control byte, 0x1E test byte, 0x04 bank-type field (data bits 3:0, bit k for group k, 0 = ground/open, 1 = supply/open; bits 7:4 dropped).
- R4: Two-byte writes 0x3A (ground/open threshold) and 0x3C (supply/open threshold) take the first data byte as bits 15:8 and the second as bits 7:0.
- R5: Reads 0x82, 0x84 (bank-type in bits 3:0, upper bits zero), 0x9E, 0xBA and 0xBC return the register, with threshold words sent high byte first.
- R6: Reads 0x90, 0x92, 0x94 and 0x96 return sense bits 7:0, 15:8, 23:16 and 31:24 respectively.
- R7: Read 0xF8 returns all 32 sense bits, bits 31:24 first, taken as one snapshot when the opcode completes.
- R8: The SO enable is low except while a read is shifting data; the first data MSB appears at the first falling SCK edge after the opcode.
- R9: SI activity during a read's data phase changes no register.
- R10: Raising chip select ends the instruction and discards any partial byte; the next instruction needs a new chip-select assertion.
- R11: Reserved opcodes change no register and read back zeros; write bytes beyond the defined count are dropped and read bits beyond it are zero.
- R12: Master reset low clears every register to zero and returns the port to waiting for an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| mr_n | input | 1 | Active-low master reset, asynchronous |
| sck | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out (valid when so_oe is high) |
| so_oe | output | 1 | Output enable for the SO pad |
| sense_in | input | 32 | Sensed input lines, 4 groups of 8 |
| ctrl_q | output | 8 | Control byte |
| bank_type_q | output | 4 | Sensing type per group |
| gnd_thr_q | output | 16 | Ground/open threshold and hysteresis word |
| sup_thr_q | output | 16 | Supply/open threshold and hysteresis word |
| test_q | output | 8 | Test byte |

## Verification
A bit counter that drifts shows up in two ways. A write lands in the wrong half of a threshold word, or a partial byte is committed. Either is visible on the parallel register outputs a few system clocks after the offending SCK edge. A wrong phase shows up on SO_OE during the opcode or after chip select rises, within one system clock of the synchronized edge. A stale or early read snapshot shows up as the wrong data on SO at the next falling SCK edge. Each read is compared bit by bit, so a slip by one position shows up in the first byte.

// File: rtl/sense_spi_pkg.sv
package sense_spi_pkg;

   typedef enum logic [1:0] {
      PH_OPC = 2'd0,
      PH_WR  = 2'd1,
      PH_RD  = 2'd2,
      PH_IGN = 2'd3
   } phase_t;

   localparam logic [7:0] OP_WR_CTRL = 8'h02;
   localparam logic [7:0] OP_WR_BANK = 8'h04;
   localparam logic [7:0] OP_WR_GND  = 8'h3A;
   localparam logic [7:0] OP_WR_SUP  = 8'h3C;
   localparam logic [7:0] OP_WR_TEST = 8'h1E;
   localparam logic [7:0] OP_RD_CTRL = 8'h82;
   localparam logic [7:0] OP_RD_BANK = 8'h84;
   localparam logic [7:0] OP_RD_GND  = 8'hBA;
   localparam logic [7:0] OP_RD_SUP  = 8'hBC;
   localparam logic [7:0] OP_RD_TEST = 8'h9E;
   localparam logic [7:0] OP_RD_GRP0 = 8'h90;
   localparam logic [7:0] OP_RD_ALL  = 8'hF8;

   // number of data bytes an opcode carries; 0 marks a reserved code
   function automatic logic [2:0] op_len(input logic [7:0] opc);
      case (opc)
         OP_WR_CTRL, OP_WR_BANK, OP_WR_TEST,
         OP_RD_CTRL, OP_RD_BANK, OP_RD_TEST,
         8'h90, 8'h92, 8'h94, 8'h96:            op_len = 3'd1;
         OP_WR_GND, OP_WR_SUP,
         OP_RD_GND, OP_RD_SUP:                  op_len = 3'd2;
         OP_RD_ALL:                             op_len = 3'd4;
         default:                               op_len = 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/sense_spi_sync.sv
module sense_spi_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sense_spi_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RST_VAL}};
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/sense_spi_engine.sv
module sense_spi_engine
   import sense_spi_pkg::*;
#(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              sck_s,
   input  logic              si_s,
   output logic [7:0]        rd_opc,
   input  logic [WORD_W-1:0] rd_word,
   output logic              wr_en,
   output logic [7:0]        wr_opc,
   output logic              wr_second,
   output logic [7:0]        wr_data,
   output logic              so_q,
   output logic              so_oe
);

   localparam int BIT_W = 3;

   phase_t           phase;
   logic             sck_d;
   logic             sck_rise;
   logic             sck_fall;
   logic [BIT_W-1:0] bit_cnt;
   logic [6:0]       sh;
   logic [7:0]       opc_q;
   logic [1:0]       byte_cnt;
   logic [2:0]       len_q;
   logic [WORD_W-1:0] tx;
   logic             byte_done;
   logic [7:0]       rx_byte;

   assign sck_rise  = sck_s & ~sck_d;
   assign sck_fall  = ~sck_s & sck_d;
   assign rx_byte   = {sh, si_s};
   assign byte_done = cs_act && sck_rise && (bit_cnt == BIT_W'(7)) && (phase != PH_RD);

   assign rd_opc    = rx_byte;
   assign wr_en     = byte_done && (phase == PH_WR);
   assign wr_opc    = opc_q;
   assign wr_second = (byte_cnt != 2'd0);
   assign wr_data   = rx_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
      end else begin
         sck_d <= sck_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_OPC;
         bit_cnt  <= '0;
         sh       <= '0;
         opc_q    <= '0;
         byte_cnt <= '0;
         len_q    <= '0;
         tx       <= '0;
         so_q     <= 1'b0;
         so_oe    <= 1'b0;
      end else if (!cs_act) begin
         phase    <= PH_OPC;
         bit_cnt  <= '0;
         byte_cnt <= '0;
         so_oe    <= 1'b0;
      end else begin
         if (sck_rise && phase != PH_RD) begin
            sh      <= rx_byte[6:0];
            bit_cnt <= bit_cnt + BIT_W'(1);
         end
         if (byte_done) begin
            case (phase)
               PH_OPC: begin
                  opc_q    <= rx_byte;
                  len_q    <= op_len(rx_byte);
                  byte_cnt <= '0;
                  if (rx_byte[7]) begin
                     phase <= PH_RD;
                     tx    <= rd_word;
                  end else if (op_len(rx_byte) != 3'd0) begin
                     phase <= PH_WR;
                  end else begin
                     phase <= PH_IGN;
                  end
               end
               PH_WR: begin
                  byte_cnt <= byte_cnt + 2'd1;
                  if (3'(byte_cnt) + 3'd1 == len_q) begin
                     phase <= PH_IGN;
                  end
               end
               default: ;
            endcase
         end
         if (sck_fall && phase == PH_RD) begin
            so_q  <= tx[WORD_W-1];
            tx    <= {tx[WORD_W-2:0], 1'b0};
            so_oe <= 1'b1;
         end
      end
   end

   // R1: output bit moves only on a falling serial clock edge
   p_so_fall_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !sck_fall |=> $stable(so_q));
   // R8: pad enable drops once chip select is released
   p_so_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !so_oe);
   // R8: pad enable only in the read data phase
   p_oe_read_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      so_oe |-> (phase == PH_RD));
   // R9: serial input is not shifted during a read
   p_si_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_RD) |=> $stable(sh));
   // R10: chip select release restarts byte framing
   p_frame_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (bit_cnt == '0));

endmodule

// File: rtl/sense_spi_regfile.sv
module sense_spi_regfile
   import sense_spi_pkg::*;
#(
   parameter int BANK_W    = 8,
   parameter int NUM_BANKS = 4,
   parameter int THR_W     = 16,
   localparam int WORD_W   = BANK_W * NUM_BANKS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [7:0]           wr_opc,
   input  logic                 wr_second,
   input  logic [7:0]           wr_data,
   input  logic [7:0]           rd_opc,
   output logic [WORD_W-1:0]    rd_word,
   input  logic [WORD_W-1:0]    sense_in,
   output logic [7:0]           ctrl_q,
   output logic [NUM_BANKS-1:0] bank_type_q,
   output logic [THR_W-1:0]     gnd_thr_q,
   output logic [THR_W-1:0]     sup_thr_q,
   output logic [7:0]           test_q
);

   localparam int HALF_W = THR_W / 2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q      <= '0;
         bank_type_q <= '0;
         gnd_thr_q   <= '0;
         sup_thr_q   <= '0;
         test_q      <= '0;
      end else if (wr_en) begin
         case (wr_opc)
            OP_WR_CTRL: ctrl_q      <= wr_data;
            OP_WR_BANK: bank_type_q <= wr_data[NUM_BANKS-1:0];
            OP_WR_TEST: test_q      <= wr_data;
            OP_WR_GND: begin
               if (wr_second) gnd_thr_q[HALF_W-1:0]     <= wr_data;
               else           gnd_thr_q[THR_W-1:HALF_W] <= wr_data;
            end
            OP_WR_SUP: begin
               if (wr_second) sup_thr_q[HALF_W-1:0]     <= wr_data;
               else           sup_thr_q[THR_W-1:HALF_W] <= wr_data;
            end
            default: ;
         endcase
      end
   end

   // read word is left aligned so the engine always shifts from the top
   always_comb begin
      rd_word = '0;
      for (int k = 0; k < NUM_BANKS; k++) begin
         if (rd_opc == OP_RD_GRP0 + 8'(2 * k)) begin
            rd_word[WORD_W-1 -: BANK_W] = sense_in[k*BANK_W +: BANK_W];
         end
      end
      case (rd_opc)
         OP_RD_CTRL: rd_word[WORD_W-1 -: 8]     = ctrl_q;
         OP_RD_BANK: rd_word[WORD_W-1 -: 8]     = 8'(bank_type_q);
         OP_RD_TEST: rd_word[WORD_W-1 -: 8]     = test_q;
         OP_RD_GND:  rd_word[WORD_W-1 -: THR_W] = gnd_thr_q;
         OP_RD_SUP:  rd_word[WORD_W-1 -: THR_W] = sup_thr_q;
         OP_RD_ALL:  rd_word                    = sense_in;
         default: ;
      endcase
   end

   // R11: registers hold unless a legal write byte completes
   p_hold_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable({ctrl_q, bank_type_q, gnd_thr_q, sup_thr_q, test_q}));
   // R3: the engine only strobes writes for defined write opcodes
   p_write_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (!wr_opc[7] && op_len(wr_opc) != 3'd0));

endmodule

// File: rtl/sense_spi_regif.sv
module sense_spi_regif
   import sense_spi_pkg::*;
#(
   parameter int BANK_W      = 8,
   parameter int NUM_BANKS   = 4,
   parameter int THR_W       = 16,
   parameter int SYNC_STAGES = 2,
   localparam int SENSE_W    = BANK_W * NUM_BANKS
) (
   input  logic                 clk,
   input  logic                 mr_n,
   input  logic                 sck,
   input  logic                 cs_n,
   input  logic                 si,
   output logic                 so,
   output logic                 so_oe,
   input  logic [SENSE_W-1:0]   sense_in,
   output logic [7:0]           ctrl_q,
   output logic [NUM_BANKS-1:0] bank_type_q,
   output logic [THR_W-1:0]     gnd_thr_q,
   output logic [THR_W-1:0]     sup_thr_q,
   output logic [7:0]           test_q
);

   if (BANK_W != 8) begin : g_bad_bank
      $error("sense_spi_regif: group width is fixed at one byte");
   end
   if (NUM_BANKS != 4) begin : g_bad_count
      $error("sense_spi_regif: opcode map defines exactly four groups");
   end
   if (THR_W != 16) begin : g_bad_thr
      $error("sense_spi_regif: threshold words are two bytes");
   end

   logic [2:0]         sync_q;
   logic               cs_act;
   logic [7:0]         rd_opc;
   logic [SENSE_W-1:0] rd_word;
   logic               wr_en;
   logic [7:0]         wr_opc;
   logic               wr_second;
   logic [7:0]         wr_data;
   logic               so_q;

   sense_spi_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (mr_n),
      .d     ({cs_n, sck, si}),
      .q     (sync_q)
   );

   assign cs_act = ~sync_q[2];

   sense_spi_engine #(
      .WORD_W (SENSE_W)
   ) u_engine (
      .clk       (clk),
      .rst_n     (mr_n),
      .cs_act    (cs_act),
      .sck_s     (sync_q[1]),
      .si_s      (sync_q[0]),
      .rd_opc    (rd_opc),
      .rd_word   (rd_word),
      .wr_en     (wr_en),
      .wr_opc    (wr_opc),
      .wr_second (wr_second),
      .wr_data   (wr_data),
      .so_q      (so_q),
      .so_oe     (so_oe)
   );

   sense_spi_regfile #(
      .BANK_W    (BANK_W),
      .NUM_BANKS (NUM_BANKS),
      .THR_W     (THR_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (mr_n),
      .wr_en       (wr_en),
      .wr_opc      (wr_opc),
      .wr_second   (wr_second),
      .wr_data     (wr_data),
      .rd_opc      (rd_opc),
      .rd_word     (rd_word),
      .sense_in    (sense_in),
      .ctrl_q      (ctrl_q),
      .bank_type_q (bank_type_q),
      .gnd_thr_q   (gnd_thr_q),
      .sup_thr_q   (sup_thr_q),
      .test_q      (test_q)
   );

   assign so = so_oe & so_q;

   // R12: master reset leaves every register cleared
   p_reset_clear_r12: assert property (@(posedge clk)
      $rose(mr_n) |-> (ctrl_q == '0 && bank_type_q == '0 && test_q == '0 && !so_oe));

endmodule

// File: tb/sense_spi_regif_tb.sv
module sense_spi_regif_tb;

   localparam int HALF = 8;

   logic        clk = 1'b0;
   logic        mr_n;
   logic        sck;
   logic        cs_n;
   logic        si;
   logic        so;
   logic        so_oe;
   logic [31:0] sense_in;
   logic [7:0]  ctrl_q;
   logic [3:0]  bank_type_q;
   logic [15:0] gnd_thr_q;
   logic [15:0] sup_thr_q;
   logic [7:0]  test_q;

   int          n_run  = 0;
   int          n_fail = 0;
   int          chg_bit = -1;
   logic [31:0] chg_val = '0;
   logic [31:0] rx;

   always #2 clk = ~clk;

   sense_spi_regif u_dut (
      .clk         (clk),
      .mr_n        (mr_n),
      .sck         (sck),
      .cs_n        (cs_n),
      .si          (si),
      .so          (so),
      .so_oe       (so_oe),
      .sense_in    (sense_in),
      .ctrl_q      (ctrl_q),
      .bank_type_q (bank_type_q),
      .gnd_thr_q   (gnd_thr_q),
      .sup_thr_q   (sup_thr_q),
      .test_q      (test_q)
   );

   // write opcode, read opcode, write data, expected read-back
   localparam logic [47:0] VEC [6] = '{
      48'h02_82_00A5_00A5,
      48'h04_84_000B_000B,
      48'h1E_9E_003C_003C,
      48'h3A_BA_1234_1234,
      48'h3C_BC_BEEF_BEEF,
      48'h04_84_00FF_000F
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic xfer(input int nbits, input logic [47:0] tx, output logic [31:0] rxo);
      logic is_rd;
      logic pre;
      int   oe_bad;
      int   st_bad;
      is_rd  = tx[47];
      oe_bad = 0;
      st_bad = 0;
      rxo    = '0;
      cs_n   = 1'b0;
      wait_clk(HALF);
      for (int i = 0; i < nbits; i++) begin
         si = tx[47-i];
         if (i == chg_bit) sense_in = chg_val;
         wait_clk(HALF);
         pre = so;
         if (i >= 8 && is_rd) begin
            rxo = {rxo[30:0], so};
            if (!so_oe) oe_bad++;
         end else if (so_oe) begin
            oe_bad++;
         end
         sck = 1'b1;
         wait_clk(HALF);
         if (so !== pre) st_bad++;
         sck = 1'b0;
      end
      wait_clk(HALF);
      cs_n = 1'b1;
      wait_clk(HALF);
      if (so_oe) oe_bad++;
      chk("R8 pad enable window", oe_bad, 0);
      chk("R1 SO steady while SCK high", st_bad, 0);
   endtask

   task automatic wr1(input logic [7:0] op, input logic [7:0] d);
      logic [31:0] dummy;
      xfer(16, {op, d, 32'h0}, dummy);
   endtask

   task automatic wr2(input logic [7:0] op, input logic [15:0] d);
      logic [31:0] dummy;
      xfer(24, {op, d, 24'h0}, dummy);
   endtask

   task automatic rd(input logic [7:0] op, input int nbytes, output logic [31:0] r);
      xfer(8 + 8 * nbytes, {op, 40'hA5_5A_C3_3C_0F}, r);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      mr_n     = 1'b0;
      sck      = 1'b0;
      cs_n     = 1'b1;
      si       = 1'b0;
      sense_in = '0;
      wait_clk(6);
      mr_n = 1'b1;
      wait_clk(6);

      // R12: reset state
      chk("R12 ctrl after reset", 32'(ctrl_q), 0);
      chk("R12 thresholds after reset", {gnd_thr_q, sup_thr_q}, 0);
      chk("R12 bank/test after reset", {20'h0, bank_type_q, test_q}, 0);
      chk("R8 pad idle after reset", 32'(so_oe), 0);

      // R3 R4 R5: vector table of write then read-back
      for (int v = 0; v < 6; v++) begin
         logic [7:0] wop;
         logic [7:0] rop;
         int         nb;
         wop = VEC[v][47:40];
         rop = VEC[v][39:32];
         nb  = (wop == 8'h3A || wop == 8'h3C) ? 2 : 1;
         if (nb == 1) wr1(wop, VEC[v][23:16]);
         else         wr2(wop, VEC[v][31:16]);
         rd(rop, nb, rx);
         chk($sformatf("R5 read-back op %h", rop), rx, 32'(VEC[v][15:0]));
      end
      chk("R3 ctrl port", 32'(ctrl_q), 32'hA5);
      chk("R3 test port", 32'(test_q), 32'h3C);
      chk("R3 bank-type port upper bits dropped", 32'(bank_type_q), 32'hF);
      chk("R4 ground threshold high byte first", 32'(gnd_thr_q), 32'h1234);
      chk("R4 supply threshold high byte first", 32'(sup_thr_q), 32'hBEEF);
      chk("R9 SI during reads left registers", {ctrl_q, test_q, gnd_thr_q}, 32'hA53C1234);

      // R6: single group reads
      sense_in = 32'h8142_C3E7;
      rd(8'h90, 1, rx); chk("R6 group 0", rx, 32'hE7);
      rd(8'h92, 1, rx); chk("R6 group 1", rx, 32'hC3);
      rd(8'h94, 1, rx); chk("R6 group 2", rx, 32'h42);
      rd(8'h96, 1, rx); chk("R6 group 3", rx, 32'h81);

      // R7: all groups, highest first, snapshot at opcode
      rd(8'hF8, 4, rx); chk("R7 all groups order", rx, 32'h8142C3E7);
      sense_in = 32'hDEAD_BEEF;
      chg_bit  = 12;
      chg_val  = 32'h0;
      rd(8'hF8, 4, rx); chk("R7 snapshot held through read", rx, 32'hDEADBEEF);
      chg_bit  = -1;
      rd(8'h90, 1, rx); chk("R7 later read sees new inputs", rx, 32'h0);

      // R10: partial byte discarded, new instruction after release works
      xfer(13, {8'h02, 8'h5A, 32'h0}, rx);
      chk("R10 partial byte dropped", 32'(ctrl_q), 32'hA5);
      wr1(8'h02, 8'h3C);
      chk("R10 next instruction accepted", 32'(ctrl_q), 32'h3C);

      // R11: extra write bytes dropped
      xfer(24, {8'h02, 8'h11, 8'h22, 24'h0}, rx);
      chk("R11 extra write byte dropped", 32'(ctrl_q), 32'h11);

      // R11: reserved write codes change nothing
      xfer(24, {8'h06, 8'h77, 8'h77, 24'h0}, rx);
      xfer(24, {8'h3B, 8'h55, 8'h66, 24'h0}, rx);
      chk("R11 reserved write ctrl/test", {ctrl_q, test_q}, 32'h113C);
      chk("R11 reserved write thresholds", {gnd_thr_q, sup_thr_q}, 32'h1234BEEF);
      chk("R11 reserved write bank type", 32'(bank_type_q), 32'hF);

      // R11: reserved read and over-long read
      rd(8'hAA, 2, rx); chk("R11 reserved read zeros", rx, 32'h0);
      rd(8'h82, 2, rx); chk("R11 extra read bits zero", rx, 32'h1100);

      // R2: read opcode with data bits does not write
      xfer(16, {8'h82, 8'h99, 32'h0}, rx);
      chk("R2 read returns ctrl", rx, 32'h11);
      chk("R2 read left ctrl", 32'(ctrl_q), 32'h11);

      // R12: master reset mid-life
      mr_n = 1'b0;
      wait_clk(4);
      mr_n = 1'b1;
      wait_clk(4);
      chk("R12 cleared thresholds", {gnd_thr_q, sup_thr_q}, 0);
      chk("R12 cleared ctrl/test/bank", {16'h0, ctrl_q, 4'h0, bank_type_q}, 0);
      wr1(8'h1E, 8'h81);
      chk("R12 port ready after reset", 32'(test_q), 32'h81);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule